// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block produces three groups of gated clock outputs (processor-rate, memory-rate and bus-rate) plus one free-running output per group, all generated as registered levels from a single fast reference clock. The processor-rate and memory-rate clocks toggle on every reference edge. The bus-rate clock is the processor clock divided by two or by three, with its rising edges aligned to processor rising edges. The PLL and any spread modulation sit outside this block.

Two asynchronous active-low stop requests, each passed through its own synchronizer, halt groups of outputs. The processor stop request halts the gated processor and memory outputs. The bus stop request halts the gated bus outputs, and only in mobile mode. Every output also has an enable bit. A global tristate bit removes the output enable. Each output's gate is re-evaluated only while that output is being loaded low. A stopped or disabled clock therefore rests at 0, never cuts a high pulse short, and restarts with a full-width high pulse.

The system must keep each processor stop request deasserted for at least 100 processor clocks, and each bus stop request deasserted for at least 10 bus clocks. The block relies on these minimum run intervals and does not enforce them.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock output and `clk_oe` are 0.
- R2: The divide ratio DIV is 2 when `pci_div3` is 0 and 3 when it is 1. Count reference edges n after reset release. `cpu_clk_free` and `sdr_clk_free` are 1 exactly when n is even and n ≥ 2. `pci_clk_free` is 1 exactly when n ≥ 2·DIV and (n mod 2·DIV) < DIV.
- R3: Every high pulse on a gated output has full nominal width. For processor and memory outputs the width is 1 reference cycle. For bus outputs it is DIV reference cycles, starting at the period start. A gated output is high only while its group's phase level is high, and this holds across stops, restarts and enable changes.
- R4: After `cpu_stop_n` falls, all `cpu_clk` and `sdr_clk` outputs are 0 from the 4th reference edge onward, and they stay 0 while the request is held.
- R5: After `cpu_stop_n` rises, the gated processor and memory outputs show a high pulse within 7 reference edges, which is fewer than 4 processor clocks.
- R6: In mobile mode (`mode_desktop` = 0), after `pci_stop_n` falls, all `pci_clk` outputs are 0 within 2·DIV+4 reference edges, and they stay 0 while the request is held.
- R7: In mobile mode, after `pci_stop_n` rises, the gated bus outputs show a high pulse within 2·DIV+4 reference edges.
- R8: With `mode_desktop` = 1, `pci_stop_n` has no effect, and each enabled `pci_clk` output equals `pci_clk_free` on every cycle.
- R9: Stop requests never affect the free-running outputs. A stop on one group leaves the other group running.
- R10: An output whose enable bit is 0 is held at 0 without switching, while its neighbours keep running. An enable change takes effect only between pulses.
- R11: `clk_oe` is 0 one reference edge after `tristate` is 1, and 1 one reference edge after `tristate` is 0. Clock levels are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; one edge is one half processor period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous active-low stop for processor and memory groups |
| pci_stop_n | input | 1 | Asynchronous active-low stop for bus group |
| mode_desktop | input | 1 | Latched mode: 1 desktop (bus stop ignored), 0 mobile |
| pci_div3 | input | 1 | Bus ratio select: 0 CPU/2, 1 CPU/3 |
| tristate | input | 1 | Global output-enable removal |
| cpu_en | input | NCPU | Per-output enables, processor group |
| sdr_en | input | NSDR | Per-output enables, memory group |
| pci_en | input | NPCI | Per-output enables, bus group |
| free_en | input | 3 | Enables for free outputs: bit0 processor, bit1 memory, bit2 bus |
| cpu_clk | output | NCPU | Gated processor clocks |
| sdr_clk | output | NSDR | Gated memory clocks |
| pci_clk | output | NPCI | Gated bus clocks |
| cpu_clk_free | output | 1 | Free-running processor clock |
| sdr_clk_free | output | 1 | Free-running memory clock |
| pci_clk_free | output | 1 | Free-running bus clock |
| clk_oe | output | 1 | Output enable for all clock pins |

## Verification
The bench drops stop requests and enable bits while a bus pulse is already high, and it uses both divide ratios. A gate that changed on any edge would cut that pulse to one or two reference cycles, and the width monitor catches such a pulse. It also holds stops long enough to catch a gate that leaks a pulse after its request has settled. It measures restart latency to catch a synchronizer or gate that waits an extra period. It runs desktop mode with the bus stop asserted, which catches a mode decode that is inverted or missing. The free-running outputs are compared against an edge-count model throughout, so any coupling from the stop logic shows up as a mismatch.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int unsigned PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  // Reference cycles per bus-clock half period.
  function automatic phase_t pci_half(input logic div3);
    return div3 ? phase_t'(3) : phase_t'(2);
  endfunction

  function automatic phase_t phase_last(input logic div3);
    return phase_t'(2 * pci_half(div3) - 1);
  endfunction

  function automatic phase_t phase_step(input phase_t ph, input logic div3);
    return (ph == phase_last(div3)) ? '0 : phase_t'(ph + 1'b1);
  endfunction

  function automatic logic cpu_level(input phase_t ph);
    return ~ph[0];
  endfunction

  function automatic logic pci_level(input phase_t ph, input logic div3);
    return ph < pci_half(div3);
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {STAGES{RST_VAL}};
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic div3_in,
  output logic cpu_lvl_n,
  output logic pci_lvl_n,
  output logic pci_start,
  output logic pci_end
);
  phase_t ph, ph_n;
  logic   div3_q, first_q, div_eff, wrap;

  // During the first period the ratio comes straight from the input;
  // afterwards it is only re-sampled at a period boundary.
  assign div_eff = first_q ? div3_in : div3_q;
  assign wrap    = (ph == phase_last(div_eff));
  assign ph_n    = phase_step(ph, div_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      div3_q  <= 1'b0;
      first_q <= 1'b1;
    end else begin
      ph <= ph_n;
      if (wrap) begin
        div3_q  <= div3_in;
        first_q <= 1'b0;
      end
    end
  end

  assign cpu_lvl_n = cpu_level(ph_n);
  assign pci_lvl_n = pci_level(ph_n, div_eff);
  assign pci_start = (ph == '0);
  assign pci_end   = (ph == pci_half(div_eff));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [N-1:0] en,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic gate_r, gate_n, out_r;

    // Gate re-evaluated only while a low level is being loaded.
    assign gate_n = lvl_n[i] ? gate_r : (req & en[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_r <= 1'b0;
        out_r  <= 1'b0;
      end else begin
        gate_r <= gate_n;
        out_r  <= lvl_n[i] & gate_n;
      end
    end

    assign q[i] = out_r;
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned NCPU        = 3,
  parameter int unsigned NSDR        = 12,
  parameter int unsigned NPCI        = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_ref,
  input  logic            rst_n,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic            mode_desktop,
  input  logic            pci_div3,
  input  logic            tristate,
  input  logic [NCPU-1:0] cpu_en,
  input  logic [NSDR-1:0] sdr_en,
  input  logic [NPCI-1:0] pci_en,
  input  logic [2:0]      free_en,
  output logic [NCPU-1:0] cpu_clk,
  output logic [NSDR-1:0] sdr_clk,
  output logic [NPCI-1:0] pci_clk,
  output logic            cpu_clk_free,
  output logic            sdr_clk_free,
  output logic            pci_clk_free,
  output logic            clk_oe
);
  localparam int unsigned NFREE = 3;

  logic             cpu_req, pci_run_s, pci_req;
  logic             cpu_lvl_n, pci_lvl_n, pci_start, pci_end;
  logic [NFREE-1:0] free_q;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cpu_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_req)
  );

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pci_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(pci_stop_n), .q(pci_run_s)
  );

  // Desktop mode ignores the bus stop request.
  assign pci_req = mode_desktop | pci_run_s;

  clkstop_phase u_phase (
    .clk(clk_ref), .rst_n(rst_n), .div3_in(pci_div3),
    .cpu_lvl_n(cpu_lvl_n), .pci_lvl_n(pci_lvl_n),
    .pci_start(pci_start), .pci_end(pci_end)
  );

  clkstop_gate #(.N(NCPU)) u_cpu_gate (
    .clk(clk_ref), .rst_n(rst_n), .req(cpu_req), .en(cpu_en),
    .lvl_n({NCPU{cpu_lvl_n}}), .q(cpu_clk)
  );

  clkstop_gate #(.N(NSDR)) u_sdr_gate (
    .clk(clk_ref), .rst_n(rst_n), .req(cpu_req), .en(sdr_en),
    .lvl_n({NSDR{cpu_lvl_n}}), .q(sdr_clk)
  );

  clkstop_gate #(.N(NPCI)) u_pci_gate (
    .clk(clk_ref), .rst_n(rst_n), .req(pci_req), .en(pci_en),
    .lvl_n({NPCI{pci_lvl_n}}), .q(pci_clk)
  );

  clkstop_gate #(.N(NFREE)) u_free_gate (
    .clk(clk_ref), .rst_n(rst_n), .req(1'b1), .en(free_en),
    .lvl_n({pci_lvl_n, cpu_lvl_n, cpu_lvl_n}), .q(free_q)
  );

  assign cpu_clk_free = free_q[0];
  assign sdr_clk_free = free_q[1];
  assign pci_clk_free = free_q[2];

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) clk_oe <= 1'b0;
    else        clk_oe <= ~tristate;
  end
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
  parameter int unsigned NCPU = 3,
  parameter int unsigned NPCI = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tristate,
  input logic            clk_oe,
  input logic            cpu_req,
  input logic [NCPU-1:0] cpu_en,
  input logic [NCPU-1:0] cpu_clk,
  input logic [NPCI-1:0] pci_en,
  input logic [NPCI-1:0] pci_clk,
  input logic            pci_start,
  input logic            pci_end
);
  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    a_r3_cpu_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk[i] |=> !cpu_clk[i]) else $error("R3 processor pulse too long");
    a_r4_cpu_held_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && $past(!cpu_req) && !cpu_clk[i]) |=> !cpu_clk[i])
      else $error("R4 stopped processor clock switched");
    a_r10_cpu_en_held_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_en[i] && $past(!cpu_en[i]) && !cpu_clk[i]) |=> !cpu_clk[i])
      else $error("R10 disabled processor clock switched");
  end

  for (genvar i = 0; i < NPCI; i++) begin : g_pci
    a_r3_pci_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_clk[i]) |-> pci_start) else $error("R3 bus pulse began mid-period");
    a_r3_pci_fall_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pci_clk[i]) |-> pci_end) else $error("R3 bus pulse truncated");
    a_r10_pci_en_held_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!pci_en[i] && $past(!pci_en[i]) && !pci_clk[i]) |=> !pci_clk[i])
      else $error("R10 disabled bus clock switched");
  end

  a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    tristate |=> !clk_oe) else $error("R11 output enable not removed");
  a_r11_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    !tristate |=> clk_oe) else $error("R11 output enable not restored");
endmodule

bind clkstop_ctrl clkstop_chk #(.NCPU(NCPU), .NPCI(NPCI)) chk_i (
  .clk(clk_ref), .rst_n(rst_n), .tristate(tristate), .clk_oe(clk_oe),
  .cpu_req(cpu_req), .cpu_en(cpu_en), .cpu_clk(cpu_clk),
  .pci_en(pci_en), .pci_clk(pci_clk), .pci_start(pci_start), .pci_end(pci_end)
);

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
  localparam int NCPU = 3;
  localparam int NSDR = 12;
  localparam int NPCI = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, mode_desktop = 1'b0;
  logic pci_div3 = 1'b0, tristate = 1'b0;
  logic [NCPU-1:0] cpu_en = '1;
  logic [NSDR-1:0] sdr_en = '1;
  logic [NPCI-1:0] pci_en = '1;
  logic [2:0]      free_en = '1;
  logic [NCPU-1:0] cpu_clk;
  logic [NSDR-1:0] sdr_clk;
  logic [NPCI-1:0] pci_clk;
  logic cpu_clk_free, sdr_clk_free, pci_clk_free, clk_oe;

  clkstop_ctrl #(.NCPU(NCPU), .NSDR(NSDR), .NPCI(NPCI)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .mode_desktop(mode_desktop), .pci_div3(pci_div3), .tristate(tristate),
    .cpu_en(cpu_en), .sdr_en(sdr_en), .pci_en(pci_en), .free_en(free_en),
    .cpu_clk(cpu_clk), .sdr_clk(sdr_clk), .pci_clk(pci_clk),
    .cpu_clk_free(cpu_clk_free), .sdr_clk_free(sdr_clk_free),
    .pci_clk_free(pci_clk_free), .clk_oe(clk_oe)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: edge count since reset release and pulse-width tracking.
  bit mon_on = 1'b0;
  int n = 0;
  int div = 2;
  int m, crun[NCPU], srun[NSDR], prun[NPCI];
  bit lc, lp, fc, fp;

  always @(posedge clk) begin
    if (!mon_on) n <= 0;
    else         n <= n + 1;
  end

  always @(negedge clk) begin
    if (!mon_on) begin
      foreach (crun[i]) crun[i] = 0;
      foreach (srun[i]) srun[i] = 0;
      foreach (prun[i]) prun[i] = 0;
    end else begin
      m  = 2 * div;
      lc = (n % 2 == 0);
      lp = ((n % m) < div);
      fc = (n >= 2) && lc;
      fp = (n >= m) && lp;
      chk(cpu_clk_free === fc, "R2 free processor clock", cpu_clk_free, fc);
      chk(sdr_clk_free === fc, "R2 free memory clock", sdr_clk_free, fc);
      chk(pci_clk_free === fp, "R2 free bus clock", pci_clk_free, fp);
      for (int i = 0; i < NCPU; i++) begin
        if (cpu_clk[i]) begin
          chk(lc, "R3 processor pulse in phase", 1, lc);
          crun[i]++;
        end else if (crun[i] != 0) begin
          chk(crun[i] == 1, "R3 processor pulse width", crun[i], 1);
          crun[i] = 0;
        end
      end
      for (int i = 0; i < NSDR; i++) begin
        if (sdr_clk[i]) begin
          chk(lc, "R3 memory pulse in phase", 1, lc);
          srun[i]++;
        end else if (srun[i] != 0) begin
          chk(srun[i] == 1, "R3 memory pulse width", srun[i], 1);
          srun[i] = 0;
        end
      end
      for (int i = 0; i < NPCI; i++) begin
        if (pci_clk[i]) begin
          chk(lp, "R3 bus pulse in phase", 1, lp);
          prun[i]++;
        end else if (prun[i] != 0) begin
          chk(prun[i] == div, "R3 bus pulse width", prun[i], div);
          prun[i] = 0;
        end
      end
    end
  end

  task automatic step(input int k);
    repeat (k) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input bit d3);
    mon_on = 1'b0;
    rst_n = 1'b0;
    pci_div3 = d3;
    div = d3 ? 3 : 2;
    step(3);
    chk({cpu_clk, sdr_clk, pci_clk, cpu_clk_free, sdr_clk_free, pci_clk_free, clk_oe} == '0,
        "R1 outputs low in reset", int'(|{cpu_clk, sdr_clk, pci_clk, clk_oe}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic run_suite(input bit d3);
    int bad, highs, lat, mm;
    bit found;
    do_reset(d3);
    mm = 2 * div;
    step(40);

    // Processor stop and restart.
    cpu_stop_n = 1'b0;
    step(7);
    bad = 0; highs = 0;
    for (int k = 0; k < 20; k++) begin
      if (cpu_clk != '0 || sdr_clk != '0) bad++;
      if (pci_clk[0]) highs++;
      step(1);
    end
    chk(bad == 0, "R4 processor and memory stopped low", bad, 0);
    chk(highs > 0, "R9 bus group runs during processor stop", highs, 1);
    cpu_stop_n = 1'b1;
    found = 0; lat = 0;
    for (int k = 1; k <= 10; k++) begin
      step(1);
      if (!found && cpu_clk[0] && sdr_clk[0]) begin found = 1; lat = k; end
    end
    chk(found && lat <= 7, "R5 processor restart latency", lat, 7);
    step(210);

    // Bus stop in mobile mode, asserted mid-pulse.
    do step(1); while (!pci_clk_free);
    pci_stop_n = 1'b0;
    step(mm + 4);
    bad = 0; highs = 0;
    for (int k = 0; k < 3 * mm; k++) begin
      if (pci_clk != '0) bad++;
      if (cpu_clk[0]) highs++;
      step(1);
    end
    chk(bad == 0, "R6 bus outputs stopped low", bad, 0);
    chk(highs > 0, "R9 processor group runs during bus stop", highs, 1);
    pci_stop_n = 1'b1;
    found = 0; lat = 0;
    for (int k = 1; k <= mm + 6; k++) begin
      step(1);
      if (!found && pci_clk[0]) begin found = 1; lat = k; end
    end
    chk(found && lat <= mm + 4, "R7 bus restart latency", lat, mm + 4);
    step(4 * mm);

    // Desktop mode ignores bus stop.
    mode_desktop = 1'b1;
    step(2);
    pci_stop_n = 1'b0;
    step(4);
    bad = 0; highs = 0;
    for (int k = 0; k < 4 * mm; k++) begin
      if (pci_clk != {NPCI{pci_clk_free}}) bad++;
      if (pci_clk[0]) highs++;
      step(1);
    end
    chk(bad == 0 && highs > 0, "R8 desktop mode ignores bus stop", bad, 0);
    pci_stop_n = 1'b1;
    step(4);
    mode_desktop = 1'b0;
    step(2 * mm);

    // Enable bits, dropped during a high pulse.
    do step(1); while (!cpu_clk[1]);
    cpu_en[1] = 1'b0;
    step(3);
    bad = 0; highs = 0;
    for (int k = 0; k < 20; k++) begin
      if (cpu_clk[1]) bad++;
      if (cpu_clk[0]) highs++;
      step(1);
    end
    chk(bad == 0 && highs > 0, "R10 disabled processor output held low", bad, 0);
    cpu_en[1] = 1'b1;
    do step(1); while (!pci_clk[2]);
    pci_en[2] = 1'b0;
    step(mm + 2);
    bad = 0; highs = 0;
    for (int k = 0; k < 3 * mm; k++) begin
      if (pci_clk[2]) bad++;
      if (pci_clk[1]) highs++;
      step(1);
    end
    chk(bad == 0 && highs > 0, "R10 disabled bus output held low", bad, 0);
    pci_en[2] = 1'b1;
    step(2 * mm);

    // Tristate.
    tristate = 1'b1;
    step(1);
    chk(clk_oe == 1'b0, "R11 output enable removed", clk_oe, 0);
    step(5);
    tristate = 1'b0;
    step(1);
    chk(clk_oe == 1'b1, "R11 output enable restored", clk_oe, 1);
    step(10);
  endtask

  initial begin
    run_suite(1'b0);
    run_suite(1'b1);
    mon_on = 1'b0;
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule